// File: doc/BRIEF.md
# Abort-on-Invalidate Monitor

This block watches the cache lines that a running transaction has marked as "abort if lost". Software marks a line when it reads critical metadata, and unmarks it on early release. The block also records which lines hold speculatively written data. When a marked line is invalidated by a remote write, or when a marked or speculatively written line is evicted locally, the block raises a synchronous abort. A failed commit also raises an abort. A successful commit, an abort, or a self-abort erases every mark.

The block also proposes a replacement victim that avoids protected lines, so the cache keeps lines whose loss would end the transaction. Abort delivery is sequenced by privilege. In user mode, the pipeline is told to push the current program counter below the user stack pointer and branch to the most recently registered handler. If the handler or the stack pointer is unusable, an exception is raised instead. In kernel mode, a vectored interrupt is requested. While the processor runs at interrupt level, delivery waits.

Top module: `aoi_monitor`

## Requirements
- R1: A snoop invalidation of a marked line makes an abort pending at the next clock edge, and the delivery pulse appears in the following cycle.
- R2: A released line is no longer marked: a later invalidation or eviction of it raises no abort.
- R3: A successful commit (`commit_ok`) or a self-abort (`self_abort`) clears all marks and all speculative-write records, and raises no abort.
- R4: A failed commit (`commit_fail`) raises an abort and clears all marks and records.
- R5: Evicting a marked line or a speculatively written line raises an abort. Evicting or invalidating an unprotected line raises none. A snoop invalidation of a line that is only speculatively written raises none.
- R6: `victim_idx` is the lowest-numbered line that is neither marked nor speculatively written, with `victim_forced` low. If every line is protected, `victim_idx` is 0 and `victim_forced` is high.
- R7: Loss detection uses the marks held before the cycle. A release in the same cycle as an invalidation does not prevent the abort, and a mark set in the same cycle as an invalidation does not cause one. When a mark and a release name the same line in one cycle, the mark wins.
- R8: In user mode (`kernel_mode`=0), delivery is a one-cycle `abort_branch` pulse. `handler_target` carries the handler, `push_value` carries `cpu_pc`, and `push_addr` carries `user_sp` minus 4.
- R9: An address is usable only if it is non-zero and its two low bits are zero. If the handler or the stack pointer is unusable at delivery time, `abort_fault` pulses instead of `abort_branch`.
- R10: In kernel mode, delivery is a one-cycle `abort_irq` pulse.
- R11: While `irq_active` is high, no delivery pulse is produced and the abort stays pending. The pulse comes in the first cycle with `irq_active` low.
- R12: At most one abort is pending. Triggers that arrive while one is pending, including in its delivery cycle, are merged and give no further pulse.
- R13: After reset, the handler is 0, nothing is pending and nothing is marked. `set_handler_v` loads the handler at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aload_v | input | 1 | Mark a line abort-on-invalidate |
| aload_idx | input | IW | Line to mark |
| arel_v | input | 1 | Release the mark of a line |
| arel_idx | input | IW | Line to release |
| tstore_v | input | 1 | Line received a speculative store |
| tstore_idx | input | IW | Line speculatively written |
| commit_ok | input | 1 | Commit succeeded |
| commit_fail | input | 1 | Commit failed |
| self_abort | input | 1 | Transaction aborted itself |
| snoop_inv_v | input | 1 | Remote invalidation of a line |
| snoop_inv_idx | input | IW | Invalidated line |
| evict_v | input | 1 | Local eviction of a line |
| evict_idx | input | IW | Evicted line |
| set_handler_v | input | 1 | Register a new abort handler |
| set_handler_addr | input | ADDR_W | Handler address |
| cpu_pc | input | ADDR_W | Current program counter |
| user_sp | input | ADDR_W | Current user stack pointer |
| kernel_mode | input | 1 | Processor in kernel mode |
| irq_active | input | 1 | Processor executing at interrupt level |
| victim_idx | output | IW | Suggested replacement line |
| victim_forced | output | 1 | Every line is protected |
| abort_branch | output | 1 | Push return address and branch to handler |
| abort_fault | output | 1 | Raise exception for bad handler or stack |
| abort_irq | output | 1 | Request vectored abort interrupt |
| handler_target | output | ADDR_W | Registered handler address |
| push_value | output | ADDR_W | Return address to push |
| push_addr | output | ADDR_W | Stack slot for the push |

## Verification
The riskiest overlap is a remote invalidation that lands in the same cycle as a release, or as a new mark, of the same line. The other risky overlap is a fresh trigger that arrives in the very cycle an earlier abort is being delivered. The bench drives each pair together in one cycle. A behavioural model that reads marks only from the previous cycle predicts whether an abort follows and how many delivery pulses appear. That prediction is compared with the outputs on every clock.

// File: rtl/aoi_mon_pkg.sv
package aoi_mon_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned ALIGN_W    = $clog2(WORD_BYTES);

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    DLV_NONE   = 2'd0,
    DLV_BRANCH = 2'd1,
    DLV_FAULT  = 2'd2,
    DLV_IRQ    = 2'd3
  } dlv_e;

  // usable: non-zero and word aligned
  function automatic logic addr_ok(addr_t a);
    return (a != '0) && (a[ALIGN_W-1:0] == '0);
  endfunction

  // slot that receives the return address
  function automatic addr_t stack_slot(addr_t sp);
    return sp - addr_t'(WORD_BYTES);
  endfunction
endpackage

// File: rtl/aoi_line_tags.sv
module aoi_line_tags #(
  parameter  int unsigned LINES = 16,
  localparam int unsigned IW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_v,
  input  logic [IW-1:0]    set_idx,
  input  logic             clr_v,
  input  logic [IW-1:0]    clr_idx,
  input  logic             tst_v,
  input  logic [IW-1:0]    tst_idx,
  input  logic             snp_v,
  input  logic [IW-1:0]    snp_idx,
  input  logic             evc_v,
  input  logic [IW-1:0]    evc_idx,
  input  logic             wipe,
  output logic [LINES-1:0] aoi_q,
  output logic [LINES-1:0] tw_q,
  output logic             loss_hit
);
  // Loss is judged on the marks held before this cycle
  logic snoop_loss, evict_loss;
  assign snoop_loss = snp_v && aoi_q[snp_idx];
  assign evict_loss = evc_v && (aoi_q[evc_idx] || tw_q[evc_idx]);
  assign loss_hit   = snoop_loss || evict_loss;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)                                aoi_q[g] <= 1'b0;
      else if (wipe)                             aoi_q[g] <= 1'b0;
      else if (set_v && set_idx == IW'(g))       aoi_q[g] <= 1'b1;
      else if (clr_v && clr_idx == IW'(g))       aoi_q[g] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                                tw_q[g] <= 1'b0;
      else if (wipe)                             tw_q[g] <= 1'b0;
      else if (tst_v && tst_idx == IW'(g))       tw_q[g] <= 1'b1;
    end
  end

  AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (aoi_q == '0 && tw_q == '0)); // R3
  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v && !wipe && !(set_v && set_idx == clr_idx)) |=> !aoi_q[$past(clr_idx)]); // R2
  AST_MARK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v && !wipe) |=> aoi_q[$past(set_idx)]); // R7
endmodule

// File: rtl/aoi_victim_pick.sv
module aoi_victim_pick #(
  parameter  int unsigned LINES = 16,
  localparam int unsigned IW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] prot,
  output logic [IW-1:0]    victim,
  output logic             forced
);
  logic found;
  always_comb begin
    victim = '0;
    found  = 1'b0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!prot[i]) begin
        victim = IW'(i);
        found  = 1'b1;
      end
    end
  end
  assign forced = !found;

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !forced |-> !prot[victim]); // R6
  AST_FORCED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    forced |-> (&prot && victim == '0)); // R6
endmodule

// File: rtl/aoi_abort_seq.sv
module aoi_abort_seq
  import aoi_mon_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trig,
  input  logic  kernel_mode,
  input  logic  irq_active,
  input  addr_t handler,
  input  addr_t sp,
  output logic  dlv_branch,
  output logic  dlv_fault,
  output logic  dlv_irq,
  output logic  pend_q
);
  logic take;
  dlv_e kind;

  assign take = pend_q && !irq_active;

  always_comb begin
    kind = DLV_NONE;
    if (take) begin
      if (kernel_mode)                          kind = DLV_IRQ;
      else if (addr_ok(handler) && addr_ok(sp)) kind = DLV_BRANCH;
      else                                      kind = DLV_FAULT;
    end
  end

  assign dlv_branch = (kind == DLV_BRANCH);
  assign dlv_fault  = (kind == DLV_FAULT);
  assign dlv_irq    = (kind == DLV_IRQ);

  // one pending abort; triggers during pending or delivery merge
  always_ff @(posedge clk) begin
    if (!rst_n)    pend_q <= 1'b0;
    else if (take) pend_q <= 1'b0;
    else if (trig) pend_q <= 1'b1;
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dlv_branch, dlv_fault, dlv_irq})); // R8
  AST_HOLD_IN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_active |-> !(dlv_branch || dlv_fault || dlv_irq)); // R11
  AST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !pend_q) |=> pend_q); // R1
  AST_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_branch || dlv_fault || dlv_irq) |=> !pend_q); // R12
endmodule

// File: rtl/aoi_monitor.sv
module aoi_monitor
  import aoi_mon_pkg::*;
#(
  parameter  int unsigned LINES = 16,
  localparam int unsigned IW    = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aload_v,
  input  logic [IW-1:0]     aload_idx,
  input  logic              arel_v,
  input  logic [IW-1:0]     arel_idx,
  input  logic              tstore_v,
  input  logic [IW-1:0]     tstore_idx,
  input  logic              commit_ok,
  input  logic              commit_fail,
  input  logic              self_abort,
  input  logic              snoop_inv_v,
  input  logic [IW-1:0]     snoop_inv_idx,
  input  logic              evict_v,
  input  logic [IW-1:0]     evict_idx,
  input  logic              set_handler_v,
  input  logic [ADDR_W-1:0] set_handler_addr,
  input  logic [ADDR_W-1:0] cpu_pc,
  input  logic [ADDR_W-1:0] user_sp,
  input  logic              kernel_mode,
  input  logic              irq_active,
  output logic [IW-1:0]     victim_idx,
  output logic              victim_forced,
  output logic              abort_branch,
  output logic              abort_fault,
  output logic              abort_irq,
  output logic [ADDR_W-1:0] handler_target,
  output logic [ADDR_W-1:0] push_value,
  output logic [ADDR_W-1:0] push_addr
);
  logic [LINES-1:0] aoi_q, tw_q;
  logic             loss_hit, abort_trig, wipe_all, pend_q;
  addr_t            handler_q;

  assign abort_trig = loss_hit || commit_fail;
  assign wipe_all   = abort_trig || commit_ok || self_abort;

  aoi_line_tags #(.LINES(LINES)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .set_v(aload_v), .set_idx(aload_idx),
    .clr_v(arel_v), .clr_idx(arel_idx),
    .tst_v(tstore_v), .tst_idx(tstore_idx),
    .snp_v(snoop_inv_v), .snp_idx(snoop_inv_idx),
    .evc_v(evict_v), .evc_idx(evict_idx),
    .wipe(wipe_all),
    .aoi_q(aoi_q), .tw_q(tw_q), .loss_hit(loss_hit)
  );

  aoi_victim_pick #(.LINES(LINES)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .prot(aoi_q | tw_q),
    .victim(victim_idx), .forced(victim_forced)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             handler_q <= '0;
    else if (set_handler_v) handler_q <= set_handler_addr;
  end

  aoi_abort_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .trig(abort_trig),
    .kernel_mode(kernel_mode), .irq_active(irq_active),
    .handler(handler_q), .sp(user_sp),
    .dlv_branch(abort_branch), .dlv_fault(abort_fault), .dlv_irq(abort_irq),
    .pend_q(pend_q)
  );

  assign handler_target = handler_q;
  assign push_value     = cpu_pc;
  assign push_addr      = stack_slot(user_sp);

  AST_FAULT_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fault |-> !kernel_mode); // R9
  AST_IRQ_KERNEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_irq |-> kernel_mode); // R10
  AST_FAIL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fail && !pend_q) |=> pend_q); // R4
  AST_HANDLER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    set_handler_v |=> handler_target == $past(set_handler_addr)); // R13
endmodule

// File: tb/test_aoi_monitor.sv
module test_aoi_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int IW = $clog2(LINES);

  logic clk = 0, rst_n = 0;
  logic aload_v = 0, arel_v = 0, tstore_v = 0, commit_ok = 0, commit_fail = 0, self_abort = 0;
  logic snoop_inv_v = 0, evict_v = 0, set_handler_v = 0, kernel_mode = 0, irq_active = 0;
  logic [IW-1:0] aload_idx = 0, arel_idx = 0, tstore_idx = 0, snoop_inv_idx = 0, evict_idx = 0;
  logic [31:0] set_handler_addr = 0, cpu_pc = 32'h40, user_sp = 32'h8000;
  logic [IW-1:0] victim_idx;
  logic victim_forced, abort_branch, abort_fault, abort_irq;
  logic [31:0] handler_target, push_value, push_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  aoi_monitor #(.LINES(LINES)) i_aoi_monitor (.*);

  int checks = 0, errors = 0;
  int n_br = 0, n_flt = 0, n_irq = 0;
  bit done = 0;
  bit m_aoi[LINES], m_tw[LINES];
  bit m_pend;
  logic [31:0] m_hdl;

  function automatic bit usable(logic [31:0] a);
    return (a != 0) && (a % 4 == 0);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    aload_v = 0; arel_v = 0; tstore_v = 0; commit_ok = 0; commit_fail = 0;
    self_abort = 0; snoop_inv_v = 0; evict_v = 0; set_handler_v = 0;
  endtask

  // compare outputs with the model, advance one clock, update the model
  task automatic tick();
    int exp_kind, vic;
    bit forced, hit, take, wipe;
    string rq;
    #1;
    exp_kind = 0;
    if (m_pend && !irq_active)
      exp_kind = kernel_mode ? 3 : ((usable(m_hdl) && usable(user_sp)) ? 1 : 2);
    rq = exp_kind == 1 ? "R8" : exp_kind == 2 ? "R9" : exp_kind == 3 ? "R10" :
         (m_pend ? "R11" : "R1");
    chk({abort_irq, abort_fault, abort_branch} ==
        (exp_kind == 0 ? 3'b000 : 3'(1 << (exp_kind - 1))),
        rq, "delivery {irq,fault,branch}", {abort_irq, abort_fault, abort_branch},
        exp_kind == 0 ? 0 : (1 << (exp_kind - 1)));
    vic = 0; forced = 1;
    for (int i = LINES - 1; i >= 0; i--)
      if (!m_aoi[i] && !m_tw[i]) begin vic = i; forced = 0; end
    chk(victim_idx == IW'(vic) && victim_forced == forced, "R6", "victim {forced,idx}",
        {victim_forced, victim_idx}, {forced, IW'(vic)});
    chk(handler_target == m_hdl && push_value == cpu_pc && push_addr == user_sp - 4,
        "R8", "target/push", handler_target ^ push_addr, m_hdl ^ (user_sp - 4));
    n_br += abort_branch; n_flt += abort_fault; n_irq += abort_irq;
    @(posedge clk);
    hit = (snoop_inv_v && m_aoi[snoop_inv_idx]) ||
          (evict_v && (m_aoi[evict_idx] || m_tw[evict_idx]));
    take = m_pend && !irq_active;
    wipe = hit || commit_fail || commit_ok || self_abort;
    if (take) m_pend = 0;
    else if (hit || commit_fail) m_pend = 1;
    if (wipe) begin
      foreach (m_aoi[i]) begin m_aoi[i] = 0; m_tw[i] = 0; end
    end else begin
      if (arel_v) m_aoi[arel_idx] = 0;
      if (aload_v) m_aoi[aload_idx] = 1;
      if (tstore_v) m_tw[tstore_idx] = 1;
    end
    if (set_handler_v) m_hdl = set_handler_addr;
    @(negedge clk);
    quiet();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic zero_counts();
    n_br = 0; n_flt = 0; n_irq = 0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (m_aoi[i]) begin m_aoi[i] = 0; m_tw[i] = 0; end
    m_pend = 0; m_hdl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R13: reset state
    chk(handler_target == 0 && !victim_forced && victim_idx == 0, "R13", "reset state",
        {victim_forced, handler_target}, 0);
    idle(2);
    set_handler_v = 1; set_handler_addr = 32'h100; tick();
    chk(handler_target == 32'h100, "R13", "handler load", handler_target, 32'h100);

    // R1: mark then lose by snoop; pulse one cycle after trigger
    zero_counts();
    aload_v = 1; aload_idx = 3; tick();
    snoop_inv_v = 1; snoop_inv_idx = 3; tick();
    #1 chk(abort_branch == 1, "R1", "pulse cycle after trigger", abort_branch, 1);
    idle(3);
    chk(n_br == 1, "R1", "branch count", n_br, 1);

    // R2: release then snoop and evict
    zero_counts();
    aload_v = 1; aload_idx = 5; tick();
    arel_v = 1; arel_idx = 5; tick();
    snoop_inv_v = 1; snoop_inv_idx = 5; tick();
    evict_v = 1; evict_idx = 5; tick();
    idle(2);
    chk(n_br + n_flt + n_irq == 0, "R2", "released line no abort", n_br, 0);

    // R3: commit and self-abort clear everything
    zero_counts();
    aload_v = 1; aload_idx = 2; tstore_v = 1; tstore_idx = 7; tick();
    commit_ok = 1; tick();
    snoop_inv_v = 1; snoop_inv_idx = 2; tick();
    evict_v = 1; evict_idx = 7; tick();
    aload_v = 1; aload_idx = 9; tick();
    self_abort = 1; tick();
    evict_v = 1; evict_idx = 9; tick();
    idle(2);
    chk(n_br + n_flt + n_irq == 0, "R3", "cleared marks no abort", n_br, 0);

    // R4: failed commit
    zero_counts();
    aload_v = 1; aload_idx = 1; tick();
    commit_fail = 1; tick(); idle(2);
    snoop_inv_v = 1; snoop_inv_idx = 1; tick(); idle(2);
    chk(n_br == 1, "R4", "failed commit one abort", n_br, 1);

    // R5: evictions and snoop of speculative-only line
    zero_counts();
    tstore_v = 1; tstore_idx = 4; tick();
    snoop_inv_v = 1; snoop_inv_idx = 4; tick(); idle(2);
    chk(n_br == 0, "R5", "snoop of written-only line", n_br, 0);
    evict_v = 1; evict_idx = 4; tick(); idle(2);
    chk(n_br == 1, "R5", "evict written line", n_br, 1);
    evict_v = 1; evict_idx = 9; tick();
    snoop_inv_v = 1; snoop_inv_idx = 10; tick(); idle(2);
    chk(n_br == 1, "R5", "unprotected line loss", n_br, 1);

    // R6: fill every line, alternating kinds
    for (int i = 0; i < LINES; i++) begin
      if (i % 2 == 0) begin aload_v = 1; aload_idx = IW'(i); end
      else begin tstore_v = 1; tstore_idx = IW'(i); end
      tick();
    end
    #1 chk(victim_forced == 1 && victim_idx == 0, "R6", "all protected",
           {victim_forced, victim_idx}, {1'b1, IW'(0)});
    commit_ok = 1; tick();

    // R7: same-cycle release vs snoop, mark vs snoop, mark vs release
    zero_counts();
    aload_v = 1; aload_idx = 6; tick();
    arel_v = 1; arel_idx = 6; snoop_inv_v = 1; snoop_inv_idx = 6; tick(); idle(2);
    chk(n_br == 1, "R7", "release same cycle still aborts", n_br, 1);
    aload_v = 1; aload_idx = 8; snoop_inv_v = 1; snoop_inv_idx = 8; tick(); idle(2);
    chk(n_br == 1, "R7", "mark same cycle no abort", n_br, 1);
    aload_v = 1; aload_idx = 10; arel_v = 1; arel_idx = 10; tick();
    snoop_inv_v = 1; snoop_inv_idx = 10; tick(); idle(2);
    chk(n_br == 2, "R7", "mark beats release", n_br, 2);
    commit_ok = 1; tick();

    // R9: bad handler, then bad stack pointer
    zero_counts();
    set_handler_v = 1; set_handler_addr = 32'h102; tick();
    commit_fail = 1; tick(); idle(2);
    chk(n_flt == 1 && n_br == 0, "R9", "misaligned handler", n_flt, 1);
    set_handler_v = 1; set_handler_addr = 32'h200; user_sp = 0; tick();
    commit_fail = 1; tick(); idle(2);
    chk(n_flt == 2, "R9", "zero stack pointer", n_flt, 2);
    user_sp = 32'h7ff0; cpu_pc = 32'h1234;
    commit_fail = 1; tick(); idle(2);
    chk(n_br == 1, "R8", "branch with good state", n_br, 1);

    // R10: kernel mode
    zero_counts();
    kernel_mode = 1;
    commit_fail = 1; tick(); idle(2);
    chk(n_irq == 1 && n_br == 0, "R10", "kernel interrupt", n_irq, 1);

    // R11 and R12: held at interrupt level, merged triggers
    zero_counts();
    kernel_mode = 0; irq_active = 1;
    commit_fail = 1; tick(); idle(3);
    aload_v = 1; aload_idx = 0; tick();
    snoop_inv_v = 1; snoop_inv_idx = 0; tick(); idle(3);
    chk(n_br == 0, "R11", "held while at interrupt level", n_br, 0);
    irq_active = 0; tick(); idle(3);
    chk(n_br == 1, "R12", "merged triggers one pulse", n_br, 1);
    zero_counts();
    commit_fail = 1; tick();
    commit_fail = 1; tick(); idle(3);
    chk(n_br == 1, "R12", "trigger in delivery cycle merged", n_br, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule